// File: doc/BRIEF.md
# Stop Level Controller

This block chooses the low-power stop level a small microcontroller enters when its processor executes a stop instruction. It then drives the enables that gate clocks and request regulator standby for that level. A one-cycle stop strobe comes with a 2-bit requested level. On that cycle the block samples the debug-enable bit and the two voltage-monitor enables. If debug or voltage monitoring has to stay alive, a request for either of the two deepest levels is lowered to the lightest level. The debug clock and full regulation are then kept.

The block leaves stop in one of two ways. An enabled wake event returns it to run. A debug wake command takes it into the active debug state, but only when debug was enabled at stop entry. A debug resume command later returns it from debug to run. While in stop, a status flag tells the debug logic that memory-access-with-status commands must report the stop condition and must not access memory.

States: `ST_RUN`, `ST_STOP1`, `ST_STOP2`, `ST_STOP3` and `ST_DEBUG`. Transitions:
- **enter**: `ST_RUN` to a stop state, on a strobe with a non-zero level.
- **wake**: a stop state to `ST_RUN`, on an enabled wake event.
- **debug_wake**: a stop state to `ST_DEBUG`, on a debug wake command while debug is kept.
- **resume**: `ST_DEBUG` to `ST_RUN`.

Top module: `stop_mode_ctrl`

## Requirements
- R1: After reset the block is in run and reports mode code 0. The peripheral, debug and periodic-interrupt clock enables are 1, the standby request is 0 and the status flag is 0.
- R2: Mode codes are run = 0, stop1 = 1, stop2 = 2, stop3 = 3 and debug = 4. In run, a stop strobe with level code 01, 10 or 11 and no keep-alive condition moves the mode to 1, 2 or 3 respectively, on the next clock edge.
- R3: A stop strobe with level code 00 is ignored, and the block stays in run with all enables unchanged.
- R4: A level 01 or 10 request becomes stop3 when the debug-enable bit is 1, or when both voltage-monitor enables are 1. One voltage-monitor enable on its own does not force stop3.
- R5: In every stop level the peripheral clock enable is 0.
- R6: In stop, the debug clock enable is 1 if debug was enabled at entry and 0 otherwise.
- R7: In stop, the standby request is 1 unless debug or both voltage-monitor enables were set at entry; in that case it is 0.
- R8: In stop, the periodic-interrupt clock enable is 0 in stop1, 1 in stop2, and 1 in stop3 unless debug was enabled at entry, in which case it is 0.
- R9: A debug wake command in stop enters debug (mode 4, all clocks on, standby 0) on the next edge if debug was enabled at entry, and is ignored otherwise. A resume command in debug returns to run.
- R10: The status flag is 1 in every stop level and 0 in run and debug.
- R11: In stop, a wake event whose enable bit is 1 returns the block to run on the next edge, and all enables return to their run values in that same cycle. An event whose enable bit is 0 is ignored.
- R12: Changes to the debug-enable or voltage-monitor bits while in stop alter neither the level nor any enable.
- R13: When a debug wake command and an enabled wake event arrive in the same cycle and debug was enabled at entry, the block enters debug.
- R14: A stop strobe while already in stop or in debug is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req | input | 1 | One-cycle stop instruction strobe |
| stop_lvl | input | 2 | Requested level code |
| dbg_en | input | 1 | Debug enable bit |
| lvde | input | 1 | Voltage monitor enable |
| lvdse | input | 1 | Voltage monitor enable in stop |
| dbg_wake | input | 1 | Debug wake command |
| dbg_go | input | 1 | Debug resume command |
| wake_evt | input | NWAKE | Wake event lines |
| wake_en | input | NWAKE | Per-line wake enables |
| mode_o | output | 3 | Current mode code |
| periph_clk_en | output | 1 | Peripheral clock enable |
| dbg_clk_en | output | 1 | Debug logic clock enable |
| reg_stby_req | output | 1 | Regulator standby request |
| rti_clk_en | output | 1 | Periodic-interrupt clock enable |
| lp_status | output | 1 | Stop condition flag for debug memory commands |

## Verification
A debug wake command and an enabled wake event can fall in the same cycle while the block sits in a stop level. The bench enters stop3 with debug enabled and raises both inputs on one clock. It then requires mode 4 with all clocks running, not mode 0. The bench also pairs a stop strobe with debug-enable changes in the cycles that follow. This shows that only the value sampled at entry sets the gating.

// File: rtl/stopctl_pkg.sv
package stopctl_pkg;
    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_STOP1 = 3'd1,
        ST_STOP2 = 3'd2,
        ST_STOP3 = 3'd3,
        ST_DEBUG = 3'd4
    } st_t;

    localparam logic [1:0] LVL_NONE = 2'b00;
    localparam logic [1:0] LVL_S1   = 2'b01;
    localparam logic [1:0] LVL_S2   = 2'b10;
    localparam logic [1:0] LVL_S3   = 2'b11;
endpackage

// File: rtl/stop_level_resolve.sv
module stop_level_resolve
    import stopctl_pkg::*;
(
    input  logic [1:0] lvl_req,
    input  logic       dbg_en,
    input  logic       lvde,
    input  logic       lvdse,
    output st_t        target,
    output logic       keep_dbg,
    output logic       keep_reg
);
    logic lvd_keep;

    always_comb begin
        lvd_keep = lvde & lvdse;
        keep_dbg = dbg_en;
        keep_reg = dbg_en | lvd_keep;
        unique case (lvl_req)
            LVL_S1:  target = keep_reg ? ST_STOP3 : ST_STOP1;
            LVL_S2:  target = keep_reg ? ST_STOP3 : ST_STOP2;
            LVL_S3:  target = ST_STOP3;
            default: target = ST_RUN;
        endcase
    end
endmodule

// File: rtl/stop_wake_detect.sv
module stop_wake_detect #(
    parameter int NWAKE = 4
) (
    input  logic [NWAKE-1:0] evt,
    input  logic [NWAKE-1:0] en,
    output logic             any_wake
);
    assign any_wake = |(evt & en);
endmodule

// File: rtl/stop_gate_decode.sv
module stop_gate_decode
    import stopctl_pkg::*;
(
    input  st_t  state,
    input  logic kept_dbg,
    input  logic kept_reg,
    output logic periph_en,
    output logic dbgclk_en,
    output logic stby_req,
    output logic rti_en,
    output logic status
);
    logic in_stop;

    always_comb begin
        in_stop   = 1'b0;
        periph_en = 1'b1;
        dbgclk_en = 1'b1;
        stby_req  = 1'b0;
        rti_en    = 1'b1;
        unique case (state)
            ST_STOP1: begin
                in_stop = 1'b1;
                rti_en  = 1'b0;
            end
            ST_STOP2: begin
                in_stop = 1'b1;
            end
            ST_STOP3: begin
                in_stop = 1'b1;
                rti_en  = ~kept_dbg;
            end
            default: begin
                in_stop = 1'b0;
            end
        endcase
        if (in_stop) begin
            periph_en = 1'b0;
            dbgclk_en = kept_dbg;
            stby_req  = ~kept_reg;
        end
        status = in_stop;
    end
endmodule

// File: rtl/stop_mode_ctrl.sv
module stop_mode_ctrl
    import stopctl_pkg::*;
#(
    parameter int NWAKE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_req,
    input  logic [1:0]       stop_lvl,
    input  logic             dbg_en,
    input  logic             lvde,
    input  logic             lvdse,
    input  logic             dbg_wake,
    input  logic             dbg_go,
    input  logic [NWAKE-1:0] wake_evt,
    input  logic [NWAKE-1:0] wake_en,
    output logic [2:0]       mode_o,
    output logic             periph_clk_en,
    output logic             dbg_clk_en,
    output logic             reg_stby_req,
    output logic             rti_clk_en,
    output logic             lp_status
);
    st_t  state_q, state_d;
    st_t  target;
    logic keep_dbg, keep_reg;
    logic kdbg_q, kreg_q;
    logic any_wake;
    logic accept;

    stop_level_resolve u_resolve (
        .lvl_req  (stop_lvl),
        .dbg_en   (dbg_en),
        .lvde     (lvde),
        .lvdse    (lvdse),
        .target   (target),
        .keep_dbg (keep_dbg),
        .keep_reg (keep_reg)
    );

    stop_wake_detect #(.NWAKE(NWAKE)) u_wake (
        .evt      (wake_evt),
        .en       (wake_en),
        .any_wake (any_wake)
    );

    assign accept = (state_q == ST_RUN) && stop_req && (stop_lvl != LVL_NONE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (accept) state_d = target;
            end
            ST_STOP1, ST_STOP2, ST_STOP3: begin
                if (dbg_wake && kdbg_q) state_d = ST_DEBUG;
                else if (any_wake)      state_d = ST_RUN;
            end
            ST_DEBUG: begin
                if (dbg_go) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            kdbg_q  <= 1'b0;
            kreg_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                kdbg_q <= keep_dbg;
                kreg_q <= keep_reg;
            end
        end
    end

    stop_gate_decode u_gate (
        .state     (state_q),
        .kept_dbg  (kdbg_q),
        .kept_reg  (kreg_q),
        .periph_en (periph_clk_en),
        .dbgclk_en (dbg_clk_en),
        .stby_req  (reg_stby_req),
        .rti_en    (rti_clk_en),
        .status    (lp_status)
    );

    assign mode_o = state_q;
endmodule

// File: rtl/stop_mode_ctrl_chk.sv
module stop_mode_ctrl_chk #(
    parameter int NWAKE = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stop_req,
    input logic [1:0]       stop_lvl,
    input logic             dbg_en,
    input logic             lvde,
    input logic             lvdse,
    input logic             dbg_wake,
    input logic [NWAKE-1:0] wake_evt,
    input logic [NWAKE-1:0] wake_en,
    input logic [2:0]       mode_o,
    input logic             periph_clk_en,
    input logic             dbg_clk_en,
    input logic             reg_stby_req,
    input logic             rti_clk_en,
    input logic             lp_status
);
    logic stopped;
    assign stopped = (mode_o >= 3'd1) && (mode_o <= 3'd3);

    p_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd0 && stop_req && stop_lvl == 2'b00) |=> (mode_o == 3'd0));

    p_forced_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd0 && stop_req && (stop_lvl == 2'b01 || stop_lvl == 2'b10)
         && (dbg_en || (lvde && lvdse))) |=> (mode_o == 3'd3));

    p_periph_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> !periph_clk_en);

    p_stby_only_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_stby_req |-> stopped);

    p_rti_dbg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd3 && dbg_clk_en) |-> !rti_clk_en);

    p_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lp_status == stopped);

    p_wake_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && |(wake_evt & wake_en) && !dbg_wake) |=> (mode_o == 3'd0 && periph_clk_en));

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && !dbg_wake && !(|(wake_evt & wake_en))) |=> $stable(mode_o) && $stable(dbg_clk_en));
endmodule

bind stop_mode_ctrl stop_mode_ctrl_chk #(.NWAKE(NWAKE)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .stop_req      (stop_req),
    .stop_lvl      (stop_lvl),
    .dbg_en        (dbg_en),
    .lvde          (lvde),
    .lvdse         (lvdse),
    .dbg_wake      (dbg_wake),
    .wake_evt      (wake_evt),
    .wake_en       (wake_en),
    .mode_o        (mode_o),
    .periph_clk_en (periph_clk_en),
    .dbg_clk_en    (dbg_clk_en),
    .reg_stby_req  (reg_stby_req),
    .rti_clk_en    (rti_clk_en),
    .lp_status     (lp_status)
);

// File: tb/stop_mode_ctrl_tb.sv
module stop_mode_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NWAKE = 4;
    localparam int NVEC = 10;

    // {lvl[2], dbg, lvde, lvdse, mode[3], periph, dbgclk, stby, rti, status}
    localparam logic [12:0] VEC [NVEC] = '{
        13'b01_000_001_00101,
        13'b10_000_010_00111,
        13'b11_000_011_00111,
        13'b01_100_011_01001,
        13'b10_100_011_01001,
        13'b10_011_011_00011,
        13'b01_010_001_00101,
        13'b01_001_001_00101,
        13'b11_111_011_01001,
        13'b00_111_000_11010
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 1'b0;
    logic [1:0] stop_lvl = 2'b00;
    logic dbg_en = 1'b0, lvde = 1'b0, lvdse = 1'b0;
    logic dbg_wake = 1'b0, dbg_go = 1'b0;
    logic [NWAKE-1:0] wake_evt = '0, wake_en = '0;
    logic [2:0] mode_o;
    logic periph_clk_en, dbg_clk_en, reg_stby_req, rti_clk_en, lp_status;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stop_mode_ctrl #(.NWAKE(NWAKE)) u_dut (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .stop_lvl(stop_lvl),
        .dbg_en(dbg_en), .lvde(lvde), .lvdse(lvdse), .dbg_wake(dbg_wake),
        .dbg_go(dbg_go), .wake_evt(wake_evt), .wake_en(wake_en),
        .mode_o(mode_o), .periph_clk_en(periph_clk_en), .dbg_clk_en(dbg_clk_en),
        .reg_stby_req(reg_stby_req), .rti_clk_en(rti_clk_en), .lp_status(lp_status)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] outs();
        return {mode_o, periph_clk_en, dbg_clk_en, reg_stby_req, rti_clk_en, lp_status};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
        stop_req = 1'b0;
        dbg_wake = 1'b0;
        dbg_go   = 1'b0;
        wake_evt = '0;
    endtask

    task automatic do_stop(input logic [1:0] l, input logic d, input logic a, input logic b);
        stop_lvl = l; dbg_en = d; lvde = a; lvdse = b; stop_req = 1'b1;
        tick();
    endtask

    task automatic do_wake();
        wake_en = 4'b0100; wake_evt = 4'b0100;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 2 + 1);
        check("R1 reset", outs(), {3'd0, 5'b11010});
        rst_n = 1'b1;
        tick();

        // Table: R2 R3 R4 R6 R7 R8 R10, then R11 wake back to run
        for (int i = 0; i < NVEC; i++) begin
            do_stop(VEC[i][12:11], VEC[i][10], VEC[i][9], VEC[i][8]);
            check("R2/R4/R5-R8/R10 vector", outs(), {VEC[i][7:5], VEC[i][4:0]});
            do_wake();
            check("R11 wake to run", outs(), {3'd0, 5'b11010});
        end

        // R11 masked event ignored
        do_stop(2'b10, 0, 0, 0);
        wake_en = 4'b0001; wake_evt = 4'b0010;
        tick();
        check("R11 masked event", outs(), {3'd2, 5'b00111});
        // R9 debug wake without debug kept is ignored
        dbg_wake = 1'b1;
        tick();
        check("R9 ignored debug wake", outs(), {3'd2, 5'b00111});
        // R14 stop strobe in stop ignored
        do_stop(2'b01, 0, 0, 0);
        check("R14 strobe in stop", outs(), {3'd2, 5'b00111});
        do_wake();

        // R12 bit changes during stop
        do_stop(2'b11, 0, 0, 0);
        dbg_en = 1'b1; lvde = 1'b1; lvdse = 1'b1;
        tick();
        tick();
        check("R12 late enable change", outs(), {3'd3, 5'b00111});
        do_wake();

        // R9 and R13: debug wake with enabled wake event in same cycle
        do_stop(2'b01, 1, 0, 0);
        check("R4 forced stop3", outs(), {3'd3, 5'b01001});
        dbg_wake = 1'b1; wake_en = 4'b1000; wake_evt = 4'b1000;
        tick();
        check("R13 debug beats wake", outs(), {3'd4, 5'b11010});
        // R14 stop strobe in debug ignored
        do_stop(2'b11, 0, 0, 0);
        check("R14 strobe in debug", outs(), {3'd4, 5'b11010});
        dbg_go = 1'b1;
        tick();
        check("R9 resume to run", outs(), {3'd0, 5'b11010});

        // R9 plain debug wake
        do_stop(2'b10, 1, 0, 0);
        dbg_wake = 1'b1;
        tick();
        check("R9 debug wake", outs(), {3'd4, 5'b11010});

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule